// File: doc/BRIEF.md
# Port Activity LED Field Formatter

This block prepares, for each of eight network ports, the short group of bits that one LED shift chain shows for that port. A downstream serializer walks the ports and shifts each port's vector out bit 0 first. A 4-bit layout code picks what goes into every port's group. The group can hold only the low bits of a software-owned status word. It can also start with one merged activity bit, or with separate transmit and receive bits, and then carry the status bits.

A transmit strobe reports that the port is sending packet data or carrier extension. A receive strobe reports a non-idle receive cycle. Both strobes can be one clock cycle long, so a stretcher widens them. The stretcher counts latch ticks from the serializer into windows of `blink_rate_i` ticks. Any strobe seen in one window lights the bit for the whole of the following window. Ports 0 to 3 belong to the first interface and ports 4 to 7 to the second. Each port has its own enable bit and its own status word.

Top module: `port_led_fmt`

## Requirements
- R1: Layout codes 0x0, 0x1, 0x2 and 0x3 give a length of 1, 2, 4 and 6 bits. Bit i of the vector is status bit i.
- R2: Layout codes 0x4, 0x5 and 0x6 give bit 0 = stretched (TX OR RX), followed by the lowest 1, 2 or 4 status bits at positions 1 and up. The lengths are 2, 3 and 5.
- R3: Layout codes 0x8, 0x9 and 0xA give bit 0 = stretched TX, bit 1 = stretched RX, followed by the lowest 1, 2 or 4 status bits at positions 2 and up. The lengths are 3, 4 and 6.
- R4: Layout codes 0x7 and 0xB to 0xF give a length of 0 and an all-zero vector for every port.
- R5: A port whose enable bit is 0 reports enable 0, length 0 and an all-zero vector. An enabled port reports enable 1.
- R6: A strobe of any length inside a window of `blink_rate_i` latch ticks sets that port's stretched bit for the whole of the next window. The bit clears at the end of a window that saw no strobe.
- R7: While `blink_rate_i` is 0, the window count, the captured activity and the stretched bits stay frozen. Strobes and ticks in that time have no effect.
- R8: Vector bits at or above the reported length are 0.
- R9: After reset, every stretched activity bit is 0 and the window starts at tick count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_act_i | input | 8 | Per-port transmit activity strobes |
| rx_act_i | input | 8 | Per-port receive activity strobes |
| status_i | input | 48 | Software status words, port p at bits [6p+5:6p] |
| layout_i | input | 4 | Field layout code |
| port_en_i | input | 8 | Per-port enable |
| blink_rate_i | input | 8 | Window length in latch ticks, 0 freezes the stretcher |
| latch_tick_i | input | 1 | One-cycle latch tick from the serializer |
| fld_bits_o | output | 48 | Per-port vector, port p at [6p+5:6p], bit 0 shifted first |
| fld_len_o | output | 24 | Per-port valid bit count, port p at [3p+2:3p] |
| fld_en_o | output | 8 | Per-port enable flag |

## Verification
The bench sweeps all sixteen layout codes over ports that show different mixes of TX and RX state. A swapped TX/RX order, a wrong status offset or mask, or a reserved code that leaks bits would corrupt at least one port's vector or length. The bench also puts a one-cycle strobe in the middle of a window and checks the bit both in the middle of the next window and after it ends. A stretcher that drops short strobes, shows them too early, or never clears would fail that test. With a zero blink rate the bench sends both ticks and strobes and checks that nothing changes. A design that kept counting, or captured the strobes, would show the wrong bit once the rate is restored.

// File: rtl/port_led_fmt.sv
module port_led_fmt #(
  parameter int NPORTS = 8,
  parameter int STW    = 6,
  parameter int RATEW  = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORTS-1:0]      tx_act_i,
  input  logic [NPORTS-1:0]      rx_act_i,
  input  logic [NPORTS*STW-1:0]  status_i,
  input  logic [3:0]             layout_i,
  input  logic [NPORTS-1:0]      port_en_i,
  input  logic [RATEW-1:0]       blink_rate_i,
  input  logic                   latch_tick_i,
  output logic [NPORTS*STW-1:0]  fld_bits_o,
  output logic [NPORTS*3-1:0]    fld_len_o,
  output logic [NPORTS-1:0]      fld_en_o
);

  localparam int LENW = 3;

  logic [RATEW-1:0]  win_cnt;
  logic [NPORTS-1:0] tx_seen, rx_seen, tx_show, rx_show;

  wire rate_on = (blink_rate_i != '0);
  wire win_run = latch_tick_i && rate_on;
  wire win_end = win_run && (win_cnt >= blink_rate_i - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_cnt <= '0;
      tx_seen <= '0;
      rx_seen <= '0;
      tx_show <= '0;
      rx_show <= '0;
    end else if (rate_on) begin
      if (win_run) win_cnt <= win_end ? '0 : win_cnt + 1'b1;
      if (win_end) begin
        tx_show <= tx_seen | tx_act_i;
        rx_show <= rx_seen | rx_act_i;
        tx_seen <= '0;
        rx_seen <= '0;
      end else begin
        tx_seen <= tx_seen | tx_act_i;
        rx_seen <= rx_seen | rx_act_i;
      end
    end
  end

  logic [1:0] pre_n;
  logic [2:0] st_n;
  logic       legal;

  always_comb begin
    legal = 1'b1;
    pre_n = 2'd0;
    st_n  = 3'd0;
    case (layout_i)
      4'h0: st_n = 3'd1;
      4'h1: st_n = 3'd2;
      4'h2: st_n = 3'd4;
      4'h3: st_n = 3'd6;
      4'h4: begin pre_n = 2'd1; st_n = 3'd1; end
      4'h5: begin pre_n = 2'd1; st_n = 3'd2; end
      4'h6: begin pre_n = 2'd1; st_n = 3'd4; end
      4'h8: begin pre_n = 2'd2; st_n = 3'd1; end
      4'h9: begin pre_n = 2'd2; st_n = 3'd2; end
      4'hA: begin pre_n = 2'd2; st_n = 3'd4; end
      default: legal = 1'b0;
    endcase
  end

  logic [STW-1:0] st_mask;
  always_comb
    for (int i = 0; i < STW; i++) st_mask[i] = (i < int'(st_n));

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [STW-1:0] pre_bits, word;
    wire live = port_en_i[p] && legal;

    always_comb begin
      pre_bits = '0;
      if (pre_n == 2'd1) pre_bits[0] = tx_show[p] | rx_show[p];
      else if (pre_n == 2'd2) pre_bits[1:0] = {rx_show[p], tx_show[p]};
    end

    assign word = pre_bits | ((status_i[p*STW +: STW] & st_mask) << pre_n);
    assign fld_bits_o[p*STW +: STW]  = live ? word : '0;
    assign fld_len_o[p*LENW +: LENW] = live ? LENW'(pre_n) + st_n : '0;
    assign fld_en_o[p] = port_en_i[p];

    a_r8_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fld_len_o[p*LENW +: LENW] <= 3'd6);
    a_r4_reserved_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (layout_i inside {4'h7, [4'hB:4'hF]}) |-> (fld_len_o[p*LENW +: LENW] == '0 && fld_bits_o[p*STW +: STW] == '0));
  end

  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (blink_rate_i == '0) |=> ($stable(tx_show) && $stable(rx_show) && $stable(win_cnt)));
  a_r6_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (|((tx_show | rx_show) & ~$past(tx_show | rx_show))) |-> $past(latch_tick_i));

endmodule

// File: tb/port_led_fmt_tb.sv
`timescale 1ns/1ps
module port_led_fmt_tb_top;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] tx = '0, rx = '0, en = '1;
  logic [N*6-1:0] st = '0;
  logic [3:0] lay = 4'h8;
  logic [7:0] rate = 8'd3;
  logic tick = 0;
  logic [N*6-1:0] bits;
  logic [N*3-1:0] len;
  logic [N-1:0] fen;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [N-1:0] m_tx = '0, m_rx = '0;

  always #4 clk = ~clk;

  port_led_fmt dut_i (.clk(clk), .rst_n(rst_n), .tx_act_i(tx), .rx_act_i(rx),
    .status_i(st), .layout_i(lay), .port_en_i(en), .blink_rate_i(rate),
    .latch_tick_i(tick), .fld_bits_o(bits), .fld_len_o(len), .fld_en_o(fen));

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] model(logic [3:0] l, logic [5:0] s, logic t, logic r, logic e);
    logic [5:0] b; int pn, sn;
    pn = 0; sn = 0; b = '0;
    case (l)
      4'h0: sn = 1; 4'h1: sn = 2; 4'h2: sn = 4; 4'h3: sn = 6;
      4'h4: begin pn = 1; sn = 1; end 4'h5: begin pn = 1; sn = 2; end
      4'h6: begin pn = 1; sn = 4; end 4'h8: begin pn = 2; sn = 1; end
      4'h9: begin pn = 2; sn = 2; end 4'hA: begin pn = 2; sn = 4; end
      default: return '0;
    endcase
    if (!e) return '0;
    if (pn == 1) b[0] = t | r;
    if (pn == 2) begin b[0] = t; b[1] = r; end
    for (int i = 0; i < sn; i++) b[pn+i] = s[i];
    return {3'(pn + sn), b};
  endfunction

  task automatic check_all(string req);
    @(negedge clk);
    for (int p = 0; p < N; p++) begin
      logic [8:0] e;
      e = model(lay, st[p*6 +: 6], m_tx[p], m_rx[p], en[p]);
      chk(req, {7'd0, len[p*3 +: 3], bits[p*6 +: 6]}, {7'd0, e});
      chk(req, {15'd0, fen[p]}, {15'd0, en[p]});
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick = 1;
    @(negedge clk) tick = 0;
  endtask

  task automatic pulse(logic [N-1:0] t, logic [N-1:0] r);
    @(negedge clk) begin tx = t; rx = r; end
    @(negedge clk) begin tx = '0; rx = '0; end
  endtask

  task automatic window();
    repeat (3) do_tick();
  endtask

  task automatic t_reset();
    check_all("R9");
  endtask

  task automatic t_layouts();
    pulse(8'b0000_1010, 8'b0000_1100);
    window();
    m_tx = 8'b0000_1010; m_rx = 8'b0000_1100;
    for (int l = 0; l < 16; l++) begin
      lay = 4'(l);
      if (l < 4) check_all("R1 R8");
      else if (l < 7) check_all("R2 R8");
      else if (l == 7 || l > 10) check_all("R4");
      else check_all("R3 R8");
    end
  endtask

  task automatic t_disable();
    en = 8'hA5; lay = 4'hA;
    check_all("R5");
    en = 8'h00; lay = 4'h3;
    check_all("R5");
    en = '1;
  endtask

  task automatic t_stretch();
    lay = 4'h8;
    window(); m_tx = '0; m_rx = '0;
    check_all("R6 clear");
    do_tick();
    pulse('0, 8'b0010_0000);
    do_tick();
    check_all("R6 not early");
    do_tick();
    m_rx = 8'b0010_0000;
    check_all("R6 shown");
    do_tick();
    check_all("R6 held mid window");
    do_tick(); do_tick();
    m_rx = '0;
    check_all("R6 cleared");
  endtask

  task automatic t_frozen();
    lay = 4'h4;
    pulse(8'b0000_0001, '0);
    window(); m_tx = 8'b0000_0001;
    check_all("R7 setup");
    rate = 8'd0;
    repeat (5) do_tick();
    pulse(8'b1000_0000, 8'b0100_0000);
    repeat (2) do_tick();
    check_all("R7 frozen");
    rate = 8'd3;
    window(); m_tx = '0;
    check_all("R7 strobes ignored");
  endtask

  initial begin
    for (int p = 0; p < N; p++) st[p*6 +: 6] = 6'(6'h2B ^ (p * 7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_layouts();
    t_disable();
    t_stretch();
    t_frozen();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule